// File: doc/BRIEF.md
# Single-Cycle Four-Instruction RISC Core

This block is a 32-bit processor core that finishes every instruction in one clock cycle. It implements a small subset of a classic three-register load/store instruction set: register-to-register arithmetic and logic, word load, word store, and branch-if-equal.

Instructions and data live in two separate word-addressed memories. A store therefore never changes the instruction stream. One register file with 32 entries serves every instruction type. One ALU computes arithmetic results, effective addresses and the branch comparison. A dedicated adder advances the program counter.

Three steering multiplexers choose the ALU's second operand, the write-back value and the destination register number. A combinational main decoder and an ALU decoder drive them. A preload port fills either memory while the core is held in reset. The current PC and every register-file write are brought out so that execution can be followed from outside.

Top module: `scp_core`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0 and `rf_we_o` is 0. `rst_ni` clears the core asynchronously, and its release passes through a two-stage synchroniser. The first instruction, at address 0, therefore retires at the third rising clock edge after `rst_ni` goes high, and `pc_o` shows 4 after that edge.
- R2: When no branch is taken, the PC advances by 4 at every rising edge. The PC stays word aligned (bits 1-0 are zero).
- R3: Opcode bits 31-26 equal 0 selects a register-to-register operation. Its operands come from registers rs (bits 25-21) and rt (bits 20-16). Its result is written to rd (bits 15-11). The function code in bits 5-0 selects the operation: 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x2A set-on-less-than.
- R4: Add and subtract wrap modulo 2^32 and still write their result when signed overflow occurs. Set-on-less-than compares signed values and gives the correct answer even when the internal subtraction overflows.
- R5: Opcode 0x23 (load word) writes data memory word (rs + sign-extended bits 15-0) >> 2 into register rt. Negative displacements are supported.
- R6: Opcode 0x2B (store word) writes register rt to data memory at the same effective address as a load. It makes no register-file write and leaves the instruction memory unchanged.
- R7: Opcode 0x04 (branch-if-equal) makes no register write. When registers rs and rt are equal, the next PC is PC+4 plus the sign-extended bits 15-0 shifted left by 2. Otherwise the next PC is PC+4.
- R8: Register 0 reads as zero. A write aimed at register 0 is dropped, and `rf_we_o` stays low for it.
- R9: A value written by a load or an ALU instruction is seen by the very next instruction that reads that register.
- R10: An unknown opcode, or opcode 0 with an unlisted function code, writes nothing and advances the PC by 4.
- R11: When `load_en_i` is high, `load_data_i` is written at the next rising edge to word `load_addr_i`. The target is the instruction memory when `load_sel_i` is 0 and the data memory when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_en_i | input | 1 | Preload write strobe |
| load_sel_i | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| load_addr_i | input | MEM_AW (6) | Preload word address |
| load_data_i | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register-file write occurs at the next rising edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value being written |

## Verification
An instruction's register write appears on `rf_we_o`, `rf_waddr_o` and `rf_wdata_o` during the same cycle in which its PC is shown. The PC moves to its successor at the next rising edge. The first instruction becomes visible three edges after reset is released.

The bench drives inputs just after a rising edge and samples outputs at the falling edge. A driver task queues every expected write, and another queues every expected PC. A monitor pops one write entry each time `rf_we_o` is high and one PC entry each time `pc_o` changes value, so a missing, extra or reordered write or branch is reported exactly when it happens. The reset latency is measured separately by counting edges from the release of reset to the first PC change.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_LDW  = 6'h23;
  localparam logic [5:0] OP_STW  = 6'h2B;
  localparam logic [5:0] OP_BEQ  = 6'h04;

  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_SLT  = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_ADD, CLS_SUB, CLS_FUNCT
  } alu_cls_e;

  typedef struct packed {
    logic dst_is_rd;
    logic b_is_imm;
    logic wb_is_mem;
    logic reg_wr;
    logic mem_wr;
    logic is_branch;
  } ctrl_t;

endpackage

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o,
  output alu_op_e    alu_op_o
);

  alu_cls_e cls;
  alu_op_e  fn_op;
  logic     fn_ok;

  always_comb begin
    fn_ok = 1'b1;
    case (funct_i)
      FN_ADD:  fn_op = ALU_ADD;
      FN_SUB:  fn_op = ALU_SUB;
      FN_AND:  fn_op = ALU_AND;
      FN_OR:   fn_op = ALU_OR;
      FN_SLT:  fn_op = ALU_SLT;
      default: begin
        fn_op = ALU_ADD;
        fn_ok = 1'b0;
      end
    endcase
  end

  always_comb begin
    ctrl_o = '0;
    cls    = CLS_ADD;
    case (opcode_i)
      OP_REG: begin
        ctrl_o.dst_is_rd = 1'b1;
        ctrl_o.reg_wr    = fn_ok;
        cls              = CLS_FUNCT;
      end
      OP_LDW: begin
        ctrl_o.b_is_imm  = 1'b1;
        ctrl_o.wb_is_mem = 1'b1;
        ctrl_o.reg_wr    = 1'b1;
      end
      OP_STW: begin
        ctrl_o.b_is_imm  = 1'b1;
        ctrl_o.mem_wr    = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.is_branch = 1'b1;
        cls              = CLS_SUB;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (cls)
      CLS_SUB:   alu_op_o = ALU_SUB;
      CLS_FUNCT: alu_op_o = fn_op;
      default:   alu_op_o = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/scp_alu.sv
module scp_alu
  import scp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);

  logic         do_sub;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         ovf;
  logic         less;

  assign do_sub = (op_i == ALU_SUB) || (op_i == ALU_SLT);
  assign b_eff  = do_sub ? ~b_i : b_i;
  assign sum    = a_i + b_eff + {{(W-1){1'b0}}, do_sub};
  assign ovf    = (a_i[W-1] == b_eff[W-1]) && (sum[W-1] != a_i[W-1]);
  assign less   = sum[W-1] ^ ovf;

  always_comb begin
    case (op_i)
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, less};
      default: y_o = sum;
    endcase
  end

  assign zero_o = (y_o == '0);

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  output logic [W-1:0]  rda_o,
  output logic [W-1:0]  rdb_o
);

  localparam int NREG = 1 << AW;

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk_i) begin
    if (we_i && (waddr_i != '0)) begin
      regs[waddr_i] <= wdata_i;
    end
  end

  assign rda_o = (ra_i == '0) ? '0 : regs[ra_i];
  assign rdb_o = (rb_i == '0) ? '0 : regs[rb_i];

endmodule

// File: rtl/scp_mem.sv
module scp_mem #(
  parameter int W  = 32,
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] words [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      words[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = words[raddr_i];

endmodule

// File: rtl/scp_core.sv
module scp_core
  import scp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MEM_AW = 6,
  parameter int REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic              load_sel_i,
  input  logic [MEM_AW-1:0] load_addr_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [DATA_W-1:0] pc_o,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o
);

  localparam int IMM_W = 16;
  localparam int EXT_W = DATA_W - IMM_W;
  localparam logic [DATA_W-1:0] STEP = DATA_W'(4);

  logic              sync_q, run_q;
  logic [DATA_W-1:0] pc_q, pc_d, pc_plus4, br_target;
  logic [DATA_W-1:0] instr, simm;
  logic [DATA_W-1:0] rs_val, rt_val, alu_b, alu_y, dmem_rd, wb_data;
  logic [REG_AW-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
  ctrl_t             ctrl;
  alu_op_e           alu_op;
  logic              alu_zero, br_take, store_we, rf_we;
  logic              imem_we, dmem_we;
  logic [MEM_AW-1:0] dmem_wa;
  logic [DATA_W-1:0] dmem_wd;

  // Reset release synchroniser
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      sync_q <= 1'b1;
      run_q  <= sync_q;
    end
  end

  // Fetch
  assign imem_we = load_en_i && !load_sel_i;

  scp_mem #(.W(DATA_W), .AW(MEM_AW)) u_imem (
    .clk_i   (clk_i),
    .we_i    (imem_we),
    .waddr_i (load_addr_i),
    .wdata_i (load_data_i),
    .raddr_i (pc_q[MEM_AW+1:2]),
    .rdata_o (instr)
  );

  // Decode
  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];
  assign simm   = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};

  scp_decode u_dec (
    .opcode_i (instr[31:26]),
    .funct_i  (instr[5:0]),
    .ctrl_o   (ctrl),
    .alu_op_o (alu_op)
  );

  scp_regfile #(.W(DATA_W), .AW(REG_AW)) u_rf (
    .clk_i   (clk_i),
    .we_i    (rf_we),
    .waddr_i (wr_idx),
    .wdata_i (wb_data),
    .ra_i    (rs_idx),
    .rb_i    (rt_idx),
    .rda_o   (rs_val),
    .rdb_o   (rt_val)
  );

  // Execute
  assign alu_b = ctrl.b_is_imm ? simm : rt_val;

  scp_alu #(.W(DATA_W)) u_alu (
    .a_i    (rs_val),
    .b_i    (alu_b),
    .op_i   (alu_op),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  // Data memory
  assign store_we = run_q && ctrl.mem_wr;
  assign dmem_we  = (load_en_i && load_sel_i) || store_we;
  assign dmem_wa  = load_en_i ? load_addr_i : alu_y[MEM_AW+1:2];
  assign dmem_wd  = load_en_i ? load_data_i : rt_val;

  scp_mem #(.W(DATA_W), .AW(MEM_AW)) u_dmem (
    .clk_i   (clk_i),
    .we_i    (dmem_we),
    .waddr_i (dmem_wa),
    .wdata_i (dmem_wd),
    .raddr_i (alu_y[MEM_AW+1:2]),
    .rdata_o (dmem_rd)
  );

  // Write back
  assign wb_data = ctrl.wb_is_mem ? dmem_rd : alu_y;
  assign wr_idx  = ctrl.dst_is_rd ? rd_idx : rt_idx;
  assign rf_we   = run_q && ctrl.reg_wr && (wr_idx != '0);

  // Next PC
  assign pc_plus4  = pc_q + STEP;
  assign br_target = pc_plus4 + {simm[DATA_W-3:0], 2'b00};
  assign br_take   = ctrl.is_branch && alu_zero;

  always_comb begin
    pc_d = br_take ? br_target : pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (run_q) begin
      pc_q <= pc_d;
    end
  end

  assign pc_o       = pc_q;
  assign rf_we_o    = rf_we;
  assign rf_waddr_o = wr_idx;
  assign rf_wdata_o = wb_data;

endmodule

// File: rtl/scp_core_chk.sv
module scp_core_chk #(
  parameter int W  = 32,
  parameter int RW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run_q,
  input logic [W-1:0]  pc_o,
  input logic          rf_we_o,
  input logic [RW-1:0] rf_waddr_o,
  input logic          store_we,
  input logic          br_take,
  input logic [W-1:0]  br_target
);

  // R1
  held_in_reset_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (pc_o == '0) && !rf_we_o && !store_we);

  // R2
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !br_take) |=> (pc_o == $past(pc_o) + W'(4)));

  // R2
  pc_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00);

  // R7
  branch_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && br_take) |=> (pc_o == $past(br_target)));

  // R6
  store_no_regwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_we |-> !rf_we_o);

  // R8
  zero_reg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (rf_waddr_o != '0));

endmodule

bind scp_core scp_core_chk #(.W(DATA_W), .RW(REG_AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_q      (run_q),
  .pc_o       (pc_o),
  .rf_we_o    (rf_we_o),
  .rf_waddr_o (rf_waddr_o),
  .store_we   (store_we),
  .br_take    (br_take),
  .br_target  (br_target)
);

// File: tb/scp_core_tb.sv
module scp_core_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        load_en_i = 1'b0;
  logic        load_sel_i = 1'b0;
  logic [5:0]  load_addr_i = '0;
  logic [31:0] load_data_i = '0;
  logic [31:0] pc_o;
  logic        rf_we_o;
  logic [4:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit monitor_on = 1'b0;
  bit done = 1'b0;

  logic [4:0]  exp_rd_q[$];
  logic [31:0] exp_wd_q[$];
  string       exp_wtag_q[$];
  logic [31:0] exp_pc_q[$];
  string       exp_ptag_q[$];
  logic [31:0] prog [64];
  logic [31:0] last_pc = '0;
  int          rel_cyc = 0;
  bit          first_move = 1'b1;

  scp_core u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_en_i   (load_en_i),
    .load_sel_i  (load_sel_i),
    .load_addr_i (load_addr_i),
    .load_data_i (load_data_i),
    .pc_o        (pc_o),
    .rf_we_o     (rf_we_o),
    .rf_waddr_o  (rf_waddr_o),
    .rf_wdata_o  (rf_wdata_o)
  );

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                        input int rt, input int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exp_write(input int rd, input logic [31:0] val, input string tag);
    exp_rd_q.push_back(rd[4:0]);
    exp_wd_q.push_back(val);
    exp_wtag_q.push_back(tag);
  endtask

  task automatic exp_pc(input logic [31:0] pc, input string tag);
    exp_pc_q.push_back(pc);
    exp_ptag_q.push_back(tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Monitor: pops the scoreboards as results appear
  always @(negedge clk_i) begin
    if (monitor_on) begin
      if (rf_we_o) begin
        if (exp_rd_q.size() == 0) begin
          check(1'b0, "R6/R7/R8/R10 unexpected write", {27'd0, rf_waddr_o}, 32'hFFFF_FFFF);
        end else begin
          logic [4:0]  erd;
          logic [31:0] ewd;
          string       etag;
          erd  = exp_rd_q.pop_front();
          ewd  = exp_wd_q.pop_front();
          etag = exp_wtag_q.pop_front();
          check(rf_waddr_o == erd, {etag, " dest"}, {27'd0, rf_waddr_o}, {27'd0, erd});
          check(rf_wdata_o == ewd, {etag, " data"}, rf_wdata_o, ewd);
        end
      end
      if (pc_o != last_pc) begin
        if (first_move) begin
          first_move = 1'b0;
          check((cyc - rel_cyc) == 3, "R1 reset release latency",
                cyc - rel_cyc, 32'd3);
        end
        if (exp_pc_q.size() == 0) begin
          check(1'b0, "R2/R7 unexpected pc", pc_o, last_pc);
        end else begin
          logic [31:0] epc;
          string       ptag;
          epc  = exp_pc_q.pop_front();
          ptag = exp_ptag_q.pop_front();
          check(pc_o == epc, ptag, pc_o, epc);
        end
        last_pc = pc_o;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) prog[i] = 32'h0;
    prog[0]  = enc_i(6'h23, 0, 1, 0);            // lw r1,0(r0)
    prog[1]  = enc_i(6'h23, 0, 2, 4);            // lw r2,4(r0)
    prog[2]  = enc_r(1, 2, 3, 6'h20);            // add r3
    prog[3]  = enc_r(3, 2, 4, 6'h22);            // sub r4
    prog[4]  = enc_r(3, 2, 5, 6'h2A);            // slt r5
    prog[5]  = enc_r(2, 3, 6, 6'h2A);            // slt r6
    prog[6]  = enc_r(1, 2, 7, 6'h24);            // and r7
    prog[7]  = enc_r(3, 2, 8, 6'h25);            // or r8
    prog[8]  = enc_r(1, 2, 0, 6'h20);            // add r0 (dropped)
    prog[9]  = enc_r(0, 2, 9, 6'h20);            // add r9,r0,r2
    prog[10] = enc_i(6'h2B, 0, 8, 48);           // sw r8,48(r0)
    prog[11] = enc_i(6'h23, 0, 11, 48);          // lw r11,48(r0)
    prog[12] = enc_r(11, 2, 12, 6'h20);          // add r12
    prog[13] = enc_i(6'h23, 0, 15, 16);          // lw r15,16(r0)
    prog[14] = enc_i(6'h23, 15, 16, -16);        // lw r16,-16(r15)
    prog[15] = enc_i(6'h04, 2, 9, 2);            // beq taken
    prog[16] = enc_r(1, 1, 17, 6'h20);           // skipped
    prog[17] = enc_r(1, 1, 18, 6'h20);           // skipped
    prog[18] = enc_i(6'h04, 2, 3, 5);            // beq not taken
    prog[19] = enc_r(2, 2, 19, 6'h20);           // add r19
    prog[20] = 32'hFC00_0000;                    // unknown opcode
    prog[21] = 32'h0000_0000;                    // unknown funct
    prog[22] = enc_r(19, 2, 20, 6'h20);          // add r20
    prog[23] = enc_i(6'h04, 0, 0, -1);           // beq self loop

    exp_write(1,  32'h7FFF_FFFF, "R5 lw r1");
    exp_write(2,  32'h0000_0001, "R5 lw r2");
    exp_write(3,  32'h8000_0000, "R4/R9 add wraps");
    exp_write(4,  32'h7FFF_FFFF, "R4 sub wraps");
    exp_write(5,  32'h0000_0001, "R4 slt with overflow");
    exp_write(6,  32'h0000_0000, "R3 slt false");
    exp_write(7,  32'h0000_0001, "R3 and");
    exp_write(8,  32'h8000_0001, "R3 or");
    exp_write(9,  32'h0000_0001, "R8 r0 reads zero");
    exp_write(11, 32'h8000_0001, "R6 load after store");
    exp_write(12, 32'h8000_0002, "R6/R9 imem intact, load use");
    exp_write(15, 32'h0000_0040, "R5 lw base");
    exp_write(16, 32'h8000_0001, "R5 negative displacement");
    exp_write(19, 32'h0000_0002, "R7 fall-through add");
    exp_write(20, 32'h0000_0003, "R10 after unknown ops");

    for (int a = 4; a <= 60; a += 4) exp_pc(a, "R2 sequential pc");
    exp_pc(72, "R7 taken branch target");
    exp_pc(76, "R7 not-taken branch");
    exp_pc(80, "R2 sequential pc");
    exp_pc(84, "R10 unknown opcode advances");
    exp_pc(88, "R10 unknown funct advances");
    exp_pc(92, "R2 sequential pc");

    #1 rst_ni = 1'b0;
    @(posedge clk_i); #2;
    for (int i = 0; i < 64; i++) begin
      load_en_i   = 1'b1;
      load_sel_i  = 1'b0;
      load_addr_i = i[5:0];
      load_data_i = prog[i];
      @(posedge clk_i); #2;
    end
    for (int i = 0; i < 5; i++) begin
      load_sel_i  = 1'b1;
      load_addr_i = i[5:0];
      case (i)
        0: load_data_i = 32'h7FFF_FFFF;
        1: load_data_i = 32'h0000_0001;
        2: load_data_i = 32'h8000_0000;
        3: load_data_i = 32'h1234_5678;
        default: load_data_i = 32'h0000_0040;
      endcase
      @(posedge clk_i); #2;
    end
    load_en_i = 1'b0;

    @(negedge clk_i);
    check(pc_o == 32'h0, "R1 pc held in reset", pc_o, 32'h0);
    check(rf_we_o == 1'b0, "R1 no write in reset", {31'd0, rf_we_o}, 32'h0);
    @(posedge clk_i); #2;
    check(pc_o == 32'h0, "R11 preload leaves pc", pc_o, 32'h0);

    rel_cyc = cyc;
    monitor_on = 1'b1;
    rst_ni = 1'b1;

    repeat (50) @(posedge clk_i);
    @(negedge clk_i);
    check(pc_o == 32'd92, "R7 self loop holds pc", pc_o, 32'd92);
    check(exp_rd_q.size() == 0, "R3/R5 all writes seen", exp_rd_q.size(), 32'd0);
    check(exp_pc_q.size() == 0, "R2/R7 all pcs seen", exp_pc_q.size(), 32'd0);
    check(first_move == 1'b0, "R1 core left reset", {31'd0, first_move}, 32'd0);
    done = 1'b1;
    finish_run();
  end

endmodule